// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes bytes from a serial receiver and places them in memory buffers. The buffers are named by a ring of 8-byte descriptors held in a local descriptor RAM. For each buffer the engine reads the descriptor at its current ring pointer. If software has marked that descriptor empty, the engine loads a down-counter with the configured maximum buffer length and writes arriving bytes one by one to consecutive addresses of the buffer. The buffer closes when the counter runs out, or earlier when a byte carries an end-of-frame or error mark. On close the engine writes the byte count and updated status back into the descriptor.

The ring has no length register. The engine steps through descriptors 8 bytes at a time. After closing a descriptor whose wrap flag is set, it goes back to the ring base. The engine checks two settings continuously. A base address that is not a multiple of eight is flagged and stops descriptors from being opened. A maximum length of zero, or an odd maximum length while wide characters are selected, is flagged in the same way. The engine has no input buffering. A byte is taken only while a buffer is open. Any other byte is discarded and flagged as dropped.

Top module: `rxbd_ring_engine`

## Requirements
- R1: After reset no buffer or descriptor write occurs, and the first descriptor read uses the ring base address.
- R2: A ring base whose three low bits are not all zero raises `cfg_base_bad`, and no descriptor read is issued while it is set.
- R3: A descriptor is used only when bit 15 (empty) of its status word is 1. Status is descriptor bits [63:48], length is [47:32] and buffer address is [31:0]. A non-empty descriptor is re-read until it becomes empty, and no bytes are written meanwhile.
- R4: Accepted bytes are written to the buffer address of the open descriptor, then to each following address in turn.
- R5: A buffer closes after exactly the maximum length in bytes. Its written length equals that maximum and its last bit (bit 11) is 0.
- R6: A byte with end-of-frame closes the buffer after that byte. The length is the number of bytes written, and the last bit is set.
- R7: A byte with the error mark closes the buffer after that byte and sets status bit 0.
- R8: Write-back puts {status, length} in the descriptor's upper 32 bits. Empty is cleared and the wrap bit (bit 13) is kept.
- R9: After a close the pointer advances by 8. After closing a descriptor with wrap set, the next read is at the ring base.
- R10: The maximum length is sampled only when a descriptor is opened. A change during a buffer affects only the next descriptor.
- R11: `cfg_len_bad` is raised for a maximum length of zero, or for an odd maximum while `cfg_wide_chars` is 1. No descriptor read is issued while it is set.
- R12: A byte arriving while no buffer is open is discarded with a one-cycle `rx_drop` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_enable | input | 1 | Allows descriptors to be opened |
| cfg_ring_base | input | BD_AW | Byte address of the first descriptor |
| cfg_max_len | input | LEN_W | Maximum bytes per buffer |
| cfg_wide_chars | input | 1 | Characters wider than 8 bits are in use |
| rx_valid | input | 1 | Receive byte present this cycle |
| rx_data | input | DW | Receive byte |
| rx_eof | input | 1 | Byte ends a frame |
| rx_err | input | 1 | Byte carries a receive error |
| rx_drop | output | 1 | Byte discarded, no buffer open |
| bd_rd_en | output | 1 | Descriptor read strobe (data next cycle) |
| bd_rd_addr | output | BD_AW | Descriptor read byte address |
| bd_rd_data | input | 64 | Descriptor contents |
| bd_wr_en | output | 1 | Descriptor write-back strobe |
| bd_wr_addr | output | BD_AW | Descriptor write-back byte address |
| bd_wr_data | output | 32 | {status, length} |
| mem_wr_en | output | 1 | Buffer byte write strobe |
| mem_wr_addr | output | BUF_AW | Buffer byte address |
| mem_wr_data | output | DW | Buffer byte |
| cfg_base_bad | output | 1 | Ring base not 8-byte aligned |
| cfg_len_bad | output | 1 | Maximum length is zero or illegally odd |

## Verification
The first frame is short and ends with end-of-frame, which separates early closing from the length limit. A longer unmarked burst then crosses a buffer boundary and runs into the wrap descriptor, which shows counter exhaustion, pointer stepping and the return to the base. Bytes sent while the engine re-reads a full descriptor show that nothing is written and that drops are flagged. The maximum length is changed in the middle of a buffer, so a close at the old limit separates per-descriptor sampling from live use of the setting. Bad bases and bad lengths are held while descriptor reads are counted, which confirms that they block fetches.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_WAIT,
      ST_COLLECT,
      ST_CLOSE
   } rxbd_state_e;

   localparam int BIT_EMPTY = 15;
   localparam int BIT_WRAP  = 13;
   localparam int BIT_LAST  = 11;
   localparam int BIT_ERR   = 0;
   localparam int BD_BYTES  = 8;
   localparam int BD_W      = 64;
endpackage

// File: rtl/rxbd_cfg_check.sv
module rxbd_cfg_check #(
   parameter int BD_AW      = 16,
   parameter int LEN_W      = 16,
   parameter bit WIDE_CHECK = 1'b1
) (
   input  logic [BD_AW-1:0] ring_base,
   input  logic [LEN_W-1:0] max_len,
   input  logic             wide_chars,
   input  logic             enable,
   output logic             base_bad,
   output logic             len_bad,
   output logic             cfg_ok
);
   localparam int ALIGN_BITS = $clog2(rxbd_pkg::BD_BYTES);

   logic odd_bad;

   assign base_bad = |ring_base[ALIGN_BITS-1:0];

   generate
      if (WIDE_CHECK) begin : g_odd_chk
         assign odd_bad = wide_chars & max_len[0];
      end else begin : g_no_odd_chk
         assign odd_bad = 1'b0;
      end
   endgenerate

   assign len_bad = (max_len == '0) | odd_bad;
   assign cfg_ok  = enable & ~base_bad & ~len_bad;
endmodule

// File: rtl/rxbd_datapath.sv
module rxbd_datapath #(
   parameter int LEN_W  = 16,
   parameter int BUF_AW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open,
   input  logic [BUF_AW-1:0] open_addr,
   input  logic [LEN_W-1:0]  max_len,
   input  logic              take,
   output logic [BUF_AW-1:0] data_ptr,
   output logic [LEN_W-1:0]  nbytes,
   output logic              last_slot
);
   logic [LEN_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain   <= '0;
         nbytes   <= '0;
         data_ptr <= '0;
      end else if (open) begin
         remain   <= max_len;
         nbytes   <= '0;
         data_ptr <= open_addr;
      end else if (take) begin
         remain   <= remain - 1'b1;
         nbytes   <= nbytes + 1'b1;
         data_ptr <= data_ptr + 1'b1;
      end
   end

   assign last_slot = (remain == LEN_W'(1));

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (remain != '0));

   // R4
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !open) |=> (data_ptr == $past(data_ptr) + 1'b1));

   // R10
   limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !open) |=> $stable(remain));
endmodule

// File: rtl/rxbd_ctrl.sv
module rxbd_ctrl #(
   parameter int BD_AW  = 16,
   parameter int LEN_W  = 16,
   parameter int BUF_AW = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_ok,
   input  logic [BD_AW-1:0]          ring_base,
   input  logic                      rx_valid,
   input  logic                      rx_eof,
   input  logic                      rx_err,
   output logic                      rx_drop,
   output logic                      bd_rd_en,
   output logic [BD_AW-1:0]          bd_rd_addr,
   input  logic [rxbd_pkg::BD_W-1:0] bd_rd_data,
   output logic                      bd_wr_en,
   output logic [BD_AW-1:0]          bd_wr_addr,
   output logic [31:0]               bd_wr_data,
   output logic                      open,
   output logic [BUF_AW-1:0]         open_addr,
   output logic                      take,
   input  logic                      last_slot,
   input  logic [LEN_W-1:0]          nbytes
);
   import rxbd_pkg::*;

   rxbd_state_e      state;
   logic [BD_AW-1:0] ptr;
   logic             reload;
   logic [15:0]      stat_q;
   logic             fin_eof;
   logic             fin_err;
   logic [BD_AW-1:0] cur_addr;
   logic [15:0]      rd_stat;
   logic [15:0]      new_stat;
   logic             close_now;

   assign cur_addr  = reload ? ring_base : ptr;
   assign rd_stat   = bd_rd_data[63:48];
   assign open_addr = bd_rd_data[BUF_AW-1:0];

   assign bd_rd_en   = (state == ST_FETCH);
   assign bd_rd_addr = cur_addr;
   assign open       = (state == ST_WAIT) && rd_stat[BIT_EMPTY];
   assign take       = (state == ST_COLLECT) && rx_valid;
   assign rx_drop    = rx_valid && (state != ST_COLLECT);
   assign close_now  = take && (last_slot || rx_eof || rx_err);

   always_comb begin
      new_stat           = stat_q;
      new_stat[BIT_EMPTY] = 1'b0;
      new_stat[BIT_LAST]  = fin_eof;
      new_stat[BIT_ERR]   = fin_err;
   end

   assign bd_wr_en   = (state == ST_CLOSE);
   assign bd_wr_addr = ptr;
   assign bd_wr_data = {new_stat, 16'(nbytes)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         ptr     <= '0;
         reload  <= 1'b1;
         stat_q  <= '0;
         fin_eof <= 1'b0;
         fin_err <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (cfg_ok) state <= ST_FETCH;
            end
            ST_FETCH: begin
               ptr    <= cur_addr;
               reload <= 1'b0;
               state  <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rd_stat[BIT_EMPTY]) begin
                  stat_q <= rd_stat;
                  state  <= ST_COLLECT;
               end else begin
                  state <= ST_IDLE;
               end
            end
            ST_COLLECT: begin
               if (close_now) begin
                  fin_eof <= rx_eof;
                  fin_err <= rx_err;
                  state   <= ST_CLOSE;
               end
            end
            ST_CLOSE: begin
               if (stat_q[BIT_WRAP]) reload <= 1'b1;
               else ptr <= ptr + BD_AW'(BD_BYTES);
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2
   fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bd_rd_en |-> (bd_rd_addr[2:0] == 3'b000));

   // R8
   wb_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bd_wr_en |-> !bd_wr_data[16 + BIT_EMPTY]);

   // R6
   close_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bd_wr_en && bd_wr_data[16 + BIT_LAST]) |-> $past(take && rx_eof));

   // R12
   drop_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_drop |-> !take);
endmodule

// File: rtl/rxbd_ring_engine.sv
module rxbd_ring_engine #(
   parameter int BD_AW      = 16,
   parameter int LEN_W      = 16,
   parameter int BUF_AW     = 32,
   parameter int DW         = 8,
   parameter bit WIDE_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic [BD_AW-1:0]  cfg_ring_base,
   input  logic [LEN_W-1:0]  cfg_max_len,
   input  logic              cfg_wide_chars,
   input  logic              rx_valid,
   input  logic [DW-1:0]     rx_data,
   input  logic              rx_eof,
   input  logic              rx_err,
   output logic              rx_drop,
   output logic              bd_rd_en,
   output logic [BD_AW-1:0]  bd_rd_addr,
   input  logic [63:0]       bd_rd_data,
   output logic              bd_wr_en,
   output logic [BD_AW-1:0]  bd_wr_addr,
   output logic [31:0]       bd_wr_data,
   output logic              mem_wr_en,
   output logic [BUF_AW-1:0] mem_wr_addr,
   output logic [DW-1:0]     mem_wr_data,
   output logic              cfg_base_bad,
   output logic              cfg_len_bad
);
   generate
      if (BD_AW < 4) begin : g_bad_aw
         $error("BD_AW too small for 8-byte descriptors");
      end
      if (LEN_W > 16 || LEN_W < 1) begin : g_bad_len
         $error("LEN_W must fit the 16-bit length field");
      end
      if (BUF_AW > 32 || BUF_AW < 1) begin : g_bad_buf
         $error("BUF_AW must fit the 32-bit address field");
      end
   endgenerate

   logic              cfg_ok;
   logic              open;
   logic [BUF_AW-1:0] open_addr;
   logic              take;
   logic              last_slot;
   logic [LEN_W-1:0]  nbytes;
   logic [BUF_AW-1:0] data_ptr;

   rxbd_cfg_check #(
      .BD_AW(BD_AW), .LEN_W(LEN_W), .WIDE_CHECK(WIDE_CHECK)
   ) u_cfg (
      .ring_base (cfg_ring_base),
      .max_len   (cfg_max_len),
      .wide_chars(cfg_wide_chars),
      .enable    (cfg_enable),
      .base_bad  (cfg_base_bad),
      .len_bad   (cfg_len_bad),
      .cfg_ok    (cfg_ok)
   );

   rxbd_ctrl #(
      .BD_AW(BD_AW), .LEN_W(LEN_W), .BUF_AW(BUF_AW)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_ok    (cfg_ok),
      .ring_base (cfg_ring_base),
      .rx_valid  (rx_valid),
      .rx_eof    (rx_eof),
      .rx_err    (rx_err),
      .rx_drop   (rx_drop),
      .bd_rd_en  (bd_rd_en),
      .bd_rd_addr(bd_rd_addr),
      .bd_rd_data(bd_rd_data),
      .bd_wr_en  (bd_wr_en),
      .bd_wr_addr(bd_wr_addr),
      .bd_wr_data(bd_wr_data),
      .open      (open),
      .open_addr (open_addr),
      .take      (take),
      .last_slot (last_slot),
      .nbytes    (nbytes)
   );

   rxbd_datapath #(
      .LEN_W(LEN_W), .BUF_AW(BUF_AW)
   ) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .open     (open),
      .open_addr(open_addr),
      .max_len  (cfg_max_len),
      .take     (take),
      .data_ptr (data_ptr),
      .nbytes   (nbytes),
      .last_slot(last_slot)
   );

   assign mem_wr_en   = take;
   assign mem_wr_addr = data_ptr;
   assign mem_wr_data = rx_data;

   // R3
   wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> !(bd_wr_en || bd_rd_en));

   // R11
   len_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_len_bad || cfg_base_bad) |-> !bd_rd_en);
endmodule

// File: tb/rxbd_ring_engine_bench.sv
module rxbd_ring_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b1;
   logic [15:0] cfg_ring_base = 16'h0044;
   logic [15:0] cfg_max_len = 16'd4;
   logic        cfg_wide_chars = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_eof = 1'b0;
   logic        rx_err = 1'b0;
   logic        rx_drop;
   logic        bd_rd_en;
   logic [15:0] bd_rd_addr;
   logic [63:0] bd_rd_data = '0;
   logic        bd_wr_en;
   logic [15:0] bd_wr_addr;
   logic [31:0] bd_wr_data;
   logic        mem_wr_en;
   logic [31:0] mem_wr_addr;
   logic [7:0]  mem_wr_data;
   logic        cfg_base_bad;
   logic        cfg_len_bad;

   int total = 0;
   int bad = 0;
   int drops = 0;
   int rd_count = 0;
   logic [15:0] first_rd = '0;
   logic [63:0] dmem [64];
   logic [39:0] mem_q [$];
   logic [47:0] bd_q [$];

   always #4 clk = ~clk;

   rxbd_ring_engine u_rxbd_ring_engine (.*);

   always @(posedge clk) begin
      if (bd_rd_en) bd_rd_data <= dmem[bd_rd_addr[8:3]];
      if (bd_wr_en) dmem[bd_wr_addr[8:3]][63:32] <= bd_wr_data;
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard queues
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_drop) drops++;
         if (bd_rd_en) begin
            if (rd_count == 0) first_rd = bd_rd_addr;
            rd_count++;
         end
         if (mem_wr_en) begin
            if (mem_q.size() == 0) check(1'b0, "R4 unexpected byte write", {mem_wr_addr, mem_wr_data}, 0);
            else begin
               logic [39:0] e;
               e = mem_q.pop_front();
               check({mem_wr_addr, mem_wr_data} == e, "R4 buffer byte", {mem_wr_addr, mem_wr_data}, e);
            end
         end
         if (bd_wr_en) begin
            if (bd_q.size() == 0) check(1'b0, "R8 unexpected write-back", {bd_wr_addr, bd_wr_data}, 0);
            else begin
               logic [47:0] e;
               e = bd_q.pop_front();
               check({bd_wr_addr, bd_wr_data} == e, "R5/R6/R7/R8/R9 write-back", {bd_wr_addr, bd_wr_data}, e);
            end
         end
      end
   end

   task automatic set_bd(input logic [15:0] a, input logic [15:0] st, input logic [31:0] buf_a);
      dmem[a[8:3]] = {st, 16'h0000, buf_a};
   endtask

   task automatic exp_byte(input logic [31:0] a, input logic [7:0] d);
      mem_q.push_back({a, d});
   endtask

   task automatic exp_close(input logic [15:0] a, input logic [15:0] st, input logic [15:0] len);
      bd_q.push_back({a, st, len});
   endtask

   task automatic send(input logic [7:0] d, input bit eof, input bit err);
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_data = d; rx_eof = eof; rx_err = err;
      @(posedge clk); #1;
      rx_valid = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
      repeat (8) @(posedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) dmem[i] = '0;
      set_bd(16'h0040, 16'h8000, 32'h1000);
      set_bd(16'h0048, 16'h8000, 32'h2000);
      set_bd(16'h0050, 16'hA000, 32'h3000);
      repeat (4) @(negedge clk);
      // R1 reset state
      check(!mem_wr_en && !bd_wr_en, "R1 no writes in reset", {mem_wr_en, bd_wr_en}, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (20) @(posedge clk);
      #1;
      // R2 misaligned base blocks fetch
      check(cfg_base_bad == 1'b1, "R2 base flag", cfg_base_bad, 1);
      check(rd_count == 0, "R2 no fetch", rd_count, 0);
      cfg_ring_base = 16'h0040;
      repeat (6) @(posedge clk); #1;
      check(cfg_base_bad == 1'b0, "R2 base flag clear", cfg_base_bad, 0);
      // R1 first fetch at base
      check(first_rd == 16'h0040, "R1 first fetch", first_rd, 16'h0040);

      // R6 short frame with end-of-frame
      exp_byte(32'h1000, 8'h11); exp_byte(32'h1001, 8'h22); exp_byte(32'h1002, 8'h33);
      exp_close(16'h0040, 16'h0800, 16'd3);
      send(8'h11, 0, 0); send(8'h22, 0, 0); send(8'h33, 1, 0);

      // R5 limit close, R9 advance and wrap
      for (int i = 0; i < 4; i++) exp_byte(32'h2000 + i, 8'h40 + 8'(i));
      exp_close(16'h0048, 16'h0000, 16'd4);
      exp_byte(32'h3000, 8'h50); exp_byte(32'h3001, 8'h51);
      exp_close(16'h0050, 16'h2800, 16'd2);
      for (int i = 0; i < 4; i++) send(8'h40 + 8'(i), 0, 0);
      send(8'h50, 0, 0); send(8'h51, 1, 0);

      // R3/R12 ring returned to full desc0: byte dropped
      send(8'h99, 0, 0);
      check(drops == 1, "R3 R12 drop on full descriptor", drops, 1);
      check(mem_q.size() == 0 && bd_q.size() == 0, "R3 nothing pending", mem_q.size(), 0);
      set_bd(16'h0040, 16'h8000, 32'h1000);
      repeat (5) @(posedge clk);
      // R7 error close
      exp_byte(32'h1000, 8'h61); exp_byte(32'h1001, 8'h62);
      exp_close(16'h0040, 16'h0001, 16'd2);
      send(8'h61, 0, 0); send(8'h62, 0, 1);

      // R10 limit changed mid-buffer
      set_bd(16'h0050, 16'hA000, 32'h3000);
      set_bd(16'h0048, 16'h8000, 32'h2000);
      repeat (5) @(posedge clk);
      for (int i = 0; i < 4; i++) exp_byte(32'h2000 + i, 8'h70 + 8'(i));
      exp_close(16'h0048, 16'h0000, 16'd4);
      exp_byte(32'h3000, 8'h80); exp_byte(32'h3001, 8'h81);
      exp_close(16'h0050, 16'h2000, 16'd2);
      send(8'h70, 0, 0); send(8'h71, 0, 0);
      cfg_max_len = 16'd2;
      send(8'h72, 0, 0); send(8'h73, 0, 0);
      send(8'h80, 0, 0); send(8'h81, 0, 0);
      // R9 wrap back to base: desc0 full again, byte dropped
      send(8'h82, 0, 0);
      check(drops == 2, "R9 R12 drop after wrap", drops, 2);

      // R11 length checks
      cfg_wide_chars = 1'b1; cfg_max_len = 16'd3; #1;
      check(cfg_len_bad == 1'b1, "R11 odd wide", cfg_len_bad, 1);
      cfg_max_len = 16'd4; #1;
      check(cfg_len_bad == 1'b0, "R11 even wide", cfg_len_bad, 0);
      cfg_wide_chars = 1'b0; cfg_max_len = 16'd3; #1;
      check(cfg_len_bad == 1'b0, "R11 odd narrow", cfg_len_bad, 0);
      cfg_max_len = 16'd0; #1;
      check(cfg_len_bad == 1'b1, "R11 zero length", cfg_len_bad, 1);
      repeat (4) @(posedge clk);
      begin
         int snap;
         snap = rd_count;
         repeat (12) @(posedge clk);
         #1;
         check(rd_count == snap, "R11 no fetch while bad", rd_count, snap);
      end
      check(mem_q.size() == 0 && bd_q.size() == 0, "R4 scoreboard drained",
            mem_q.size() + bd_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule